// File: doc/BRIEF.md
# Bit-Serial Shift-Add Readout Accumulator

This block is the digital back end behind an analog in-memory multiply array. A single ADC, time-shared across a group of columns, delivers one digitized partial sum per beat. Each beat carries tags for its source:
- the column;
- the weight cell slice, since a multi-bit weight is split across several adjacent low-precision cells;
- the input bit position, since activations are driven bit-serially;
- the array polarity, positive or negative.

The block turns that stream of codes into one signed dot product. It does this in four steps:
- It weights every code by the significance of its cell slice and of its input bit.
- It treats the top input bit as the two's-complement sign bit.
- It takes the negative-array reads away from the positive-array reads.
- It removes a per-column baseline.

The baseline comes from reference reads of the same column, taken with the modulation input at zero. Reference beats travel on the same stream, marked by a flag. They only load the baseline store and are never counted or accumulated.

A result is complete once every combination of column, slice, input bit and polarity has arrived exactly once. That is 512 main beats with the default parameters, and they may arrive in any order. The result is then presented for one cycle. The next dot product starts from zero, while the stored baselines are kept.

Input stream rules:
- A beat transfers on a rising edge where `in_valid` and `in_ready` are both high.
- The block drops `in_ready` for exactly one cycle: the cycle in which it presents a result.
- A source may hold `in_valid` high through that cycle. The beat then transfers on the next edge.
- The result output has no back-pressure.

Top module: `rdo_shiftadd_acc`

## Requirements
- R1: After reset, `res_valid` is 0, `in_ready` is 1, every column baseline is zero and the running sum is zero.
- R2: A main beat from cell slice k (field `in_slice`, 0 is least significant) is weighted by 2^(2k), because each cell holds 2 bits.
- R3: A main beat for input bit i (field `in_ibit`, 0 = LSB) is weighted by 2^i. For i = 7, the sign bit, the weighted term is subtracted.
- R4: A main beat with `in_neg` = 1 comes from the negative array, and its weighted term has the opposite sign to the same beat with `in_neg` = 0.
- R5: A beat with `in_ref` = 1 stores its code as the baseline of column `in_col`. It adds nothing to the sum and does not count toward completion. Each main beat of column c contributes (code − baseline[c]), weighted as in R2–R4.
- R6: The accepted beat that completes all 512 main tag combinations is followed, in the very next cycle, by `res_valid` = 1 for exactly one cycle. `res_data` in that cycle holds the signed 28-bit dot product.
- R7: `in_ready` is 0 exactly while `res_valid` is 1. A beat offered in that cycle is not taken.
- R8: After a result, the next dot product accumulates from zero, and the column baselines stored earlier still apply.
- R9: The full-scale cases produce the exact value in 28-bit two's complement, without wrapping. Example: all positive-array reads at code 255 on bits 0–6, and all negative-array reads at code 255 on bit 7, with zero baselines, give 44,217,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_code | input | 8 | Unsigned ADC code |
| in_col | input | 3 | Column index of the code |
| in_slice | input | 2 | Weight cell slice index |
| in_ibit | input | 3 | Input bit position, 7 is the sign bit |
| in_neg | input | 1 | 1 = negative array, 0 = positive array |
| in_ref | input | 1 | 1 = reference read that loads the column baseline |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 28 | Signed dot product, two's complement |

## Verification
Every result is due in the cycle right after the edge that accepts the completing main beat. The bench drives beats on falling edges and reads `res_valid`, `res_data` and `in_ready` at the falling edge that follows that acceptance. It then looks once more, one cycle later, to confirm the strobe has gone.

During the stall cycle the bench offers a beat that would corrupt the sum. The exact value and timing of the next result then show whether that beat was taken. A reference beat is also slipped into the middle of a run. If it were counted, the result would arrive one beat early and miss its sampling point.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } rdo_pol_e;

  // Sum of slice weights 1 + 2^b + 2^(2b) + ... used for range bounds.
  function automatic longint slice_weight_sum(input int cell_bits, input int slices);
    longint s;
    s = 0;
    for (int k = 0; k < slices; k++) s += longint'(1) << (k * cell_bits);
    return s;
  endfunction

endpackage

// File: rtl/rdo_base_bank.sv
module rdo_base_bank #(
  parameter int COLS   = 8,
  parameter int CODE_W = 8,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [COL_W-1:0]  rd_col,
  output logic [CODE_W-1:0] rd_base
);

  logic [CODE_W-1:0] base_q [COLS];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[c] <= '0;
      end else if (wr_en && (wr_col == COL_W'(c))) begin
        base_q[c] <= wr_code;
      end
    end
  end

  assign rd_base = base_q[rd_col];

endmodule

// File: rtl/rdo_term.sv
module rdo_term #(
  parameter int CODE_W    = 8,
  parameter int CELL_BITS = 2,
  parameter int SLICES    = 4,
  parameter int IN_BITS   = 8,
  parameter int ACC_W     = 28,
  localparam int SL_W     = $clog2(SLICES),
  localparam int IB_W     = $clog2(IN_BITS),
  localparam int SH_W     = $clog2((SLICES - 1) * CELL_BITS + IN_BITS)
) (
  input  logic [CODE_W-1:0]       code,
  input  logic [CODE_W-1:0]       base,
  input  logic [SL_W-1:0]         slice,
  input  logic [IB_W-1:0]         ibit,
  input  rdo_pkg::rdo_pol_e       pol,
  output logic signed [ACC_W-1:0] term
);

  logic signed [CODE_W:0]   diff;
  logic signed [ACC_W-1:0]  diff_ext;
  logic signed [ACC_W-1:0]  shifted;
  logic [SH_W-1:0]          shamt;
  logic                     is_sign_bit;
  logic                     flip;

  always_comb begin
    diff        = $signed({1'b0, code}) - $signed({1'b0, base});
    diff_ext    = {{(ACC_W - CODE_W - 1){diff[CODE_W]}}, diff};
    shamt       = SH_W'(slice) * SH_W'(CELL_BITS) + SH_W'(ibit);
    shifted     = diff_ext <<< shamt;
    is_sign_bit = (ibit == IB_W'(IN_BITS - 1));
    flip        = is_sign_bit ^ (pol == rdo_pkg::POL_NEG);
    term        = flip ? -shifted : shifted;
  end

endmodule

// File: rtl/rdo_beat_count.sv
module rdo_beat_count #(
  parameter int BEATS  = 512,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic wrap
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap = step && (cnt_q == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rdo_shiftadd_acc.sv
module rdo_shiftadd_acc #(
  parameter int CODE_W    = 8,
  parameter int CELL_BITS = 2,
  parameter int SLICES    = 4,
  parameter int IN_BITS   = 8,
  parameter int COLS      = 8,
  parameter int ACC_W     = 28,
  localparam int COL_W    = $clog2(COLS),
  localparam int SL_W     = $clog2(SLICES),
  localparam int IB_W     = $clog2(IN_BITS),
  localparam int BEATS    = 2 * COLS * SLICES * IN_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [COL_W-1:0] in_col,
  input  logic [SL_W-1:0]  in_slice,
  input  logic [IB_W-1:0]  in_ibit,
  input  logic             in_neg,
  input  logic             in_ref,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data
);

  logic                    take;
  logic                    take_main;
  logic                    take_ref;
  logic                    last_beat;
  logic [CODE_W-1:0]       col_base;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;
  rdo_pkg::rdo_pol_e       pol;

  assign in_ready  = !res_valid;
  assign take      = in_valid && in_ready;
  assign take_main = take && !in_ref;
  assign take_ref  = take && in_ref;
  assign pol       = in_neg ? rdo_pkg::POL_NEG : rdo_pkg::POL_POS;

  rdo_base_bank #(
    .COLS   (COLS),
    .CODE_W (CODE_W)
  ) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_ref),
    .wr_col  (in_col),
    .wr_code (in_code),
    .rd_col  (in_col),
    .rd_base (col_base)
  );

  rdo_term #(
    .CODE_W    (CODE_W),
    .CELL_BITS (CELL_BITS),
    .SLICES    (SLICES),
    .IN_BITS   (IN_BITS),
    .ACC_W     (ACC_W)
  ) u_term (
    .code  (in_code),
    .base  (col_base),
    .slice (in_slice),
    .ibit  (in_ibit),
    .pol   (pol),
    .term  (term)
  );

  rdo_beat_count #(
    .BEATS (BEATS)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (take_main),
    .wrap  (last_beat)
  );

  assign acc_next = acc_q + term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= last_beat;
      if (take_main) begin
        if (last_beat) begin
          res_data <= acc_next;
          acc_q    <= '0;
        end else begin
          acc_q    <= acc_next;
        end
      end
    end
  end

endmodule

// File: rtl/rdo_shiftadd_acc_chk.sv
module rdo_shiftadd_acc_chk #(
  parameter int CODE_W    = 8,
  parameter int CELL_BITS = 2,
  parameter int SLICES    = 4,
  parameter int IN_BITS   = 8,
  parameter int COLS      = 8,
  parameter int ACC_W     = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_ref,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_data
);

  localparam longint MAG = longint'(2 * COLS) * ((longint'(1) << CODE_W) - 1)
                         * rdo_pkg::slice_weight_sum(CELL_BITS, SLICES)
                         * ((longint'(1) << IN_BITS) - 1);

  // R6
  res_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R6
  res_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(in_valid && in_ready && !in_ref));

  // R5
  ref_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ref) |=> !res_valid);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (longint'($signed(res_data)) <= MAG && longint'($signed(res_data)) >= -MAG));

endmodule

bind rdo_shiftadd_acc rdo_shiftadd_acc_chk #(
  .CODE_W    (CODE_W),
  .CELL_BITS (CELL_BITS),
  .SLICES    (SLICES),
  .IN_BITS   (IN_BITS),
  .COLS      (COLS),
  .ACC_W     (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ref    (in_ref),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/rdo_shiftadd_acc_tb.sv
`timescale 1ns/1ps
module rdo_shiftadd_acc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_code = '0;
  logic [2:0] in_col = '0;
  logic [1:0] in_slice = '0;
  logic [2:0] in_ibit = '0;
  logic       in_neg = 1'b0;
  logic       in_ref = 1'b0;
  logic       res_valid;
  logic [27:0] res_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] cq [512];
  int base_tb [8];

  always #2.5 clk = ~clk;

  rdo_shiftadd_acc u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_col(in_col), .in_slice(in_slice), .in_ibit(in_ibit),
    .in_neg(in_neg), .in_ref(in_ref), .res_valid(res_valid), .res_data(res_data)
  );

  // Single-beat vectors: one beat departs from its column baseline.
  localparam int NV = 8;
  localparam int T_COL  [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int T_SL   [NV] = '{0, 1, 3, 0, 0, 2, 3, 1};
  localparam int T_IB   [NV] = '{0, 0, 0, 3, 7, 1, 7, 2};
  localparam int T_NEG  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam int T_CODE [NV] = '{20, 23, 17, 29, 32, 35, 38, 0};
  localparam int T_EXP  [NV] = '{10, 40, 64, 80, -1280, -320, 81920, -496};
  localparam string T_REQ [NV] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4", "R5"};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bidx(input int pol, input int col, input int sl, input int ib);
    return ((pol * 8 + col) * 4 + sl) * 8 + ib;
  endfunction

  task automatic send_ref(input int col, input int code);
    @(negedge clk);
    in_valid = 1'b1; in_ref = 1'b1; in_col = 3'(col); in_code = 8'(code);
    in_slice = '0; in_ibit = '0; in_neg = 1'b0;
    base_tb[col] = code;
  endtask

  task automatic fill_flat();
    for (int i = 0; i < 512; i++) cq[i] = 8'(base_tb[(i >> 5) & 7]);
  endtask

  task automatic run_dot(input longint expv, input string req, input bit mid_ref);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_ref = 1'b0; in_code = cq[i];
      in_neg = i[8]; in_col = i[7:5]; in_slice = i[4:3]; in_ibit = i[2:0];
      if (mid_ref && i == 100) send_ref(0, base_tb[0]);
    end
    @(negedge clk);
    chk(res_valid === 1'b1, "R6", longint'(res_valid), 1);
    chk(longint'($signed(res_data)) == expv, req, longint'($signed(res_data)), expv);
    chk(in_ready === 1'b0, "R7", longint'(in_ready), 0);
    // R7: offer a damaging beat during the stall; it must not be taken.
    in_valid = 1'b1; in_ref = 1'b0; in_code = 8'd255; in_col = '0;
    in_slice = 2'd3; in_ibit = 3'd6; in_neg = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(res_valid === 1'b0, "R6", longint'(res_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(res_valid === 1'b0, "R1", longint'(res_valid), 0);
    chk(in_ready === 1'b1, "R1", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", longint'(in_ready), 1);

    // R1: baselines are zero after reset
    for (int c = 0; c < 8; c++) base_tb[c] = 0;
    fill_flat();
    cq[bidx(0, 0, 0, 0)] = 8'd5;
    run_dot(5, "R1", 1'b0);

    // Table of single-beat vectors
    for (int c = 0; c < 8; c++) send_ref(c, 10 + 3 * c);
    for (int v = 0; v < NV; v++) begin
      fill_flat();
      cq[bidx(T_NEG[v], T_COL[v], T_SL[v], T_IB[v])] = 8'(T_CODE[v]);
      run_dot(T_EXP[v], T_REQ[v], v == 2);
    end

    // R9: full scale, zero baselines
    for (int c = 0; c < 8; c++) send_ref(c, 0);
    for (int i = 0; i < 512; i++)
      cq[i] = ((i[8] == 1'b0 && i[2:0] != 3'd7) || (i[8] == 1'b1 && i[2:0] == 3'd7)) ? 8'd255 : 8'd0;
    run_dot(44217000, "R9", 1'b0);

    // Random dot products; second and third reuse stored baselines (R8)
    for (int r = 0; r < 3; r++) begin
      longint expv;
      int rows [8];
      int wp [8];
      int wn [8];
      int xv [8];
      if (r == 0) for (int c = 0; c < 8; c++) send_ref(c, int'($urandom_range(40, 0)));
      expv = 0;
      for (int c = 0; c < 8; c++) begin
        rows[c] = int'($urandom_range(60, 1));
        wp[c] = int'($urandom_range(255, 0));
        wn[c] = int'($urandom_range(255, 0));
        xv[c] = int'($signed(8'($urandom_range(255, 0))));
        expv += longint'(rows[c]) * (wp[c] - wn[c]) * xv[c];
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 4; s++)
            for (int b = 0; b < 8; b++)
              cq[bidx(p, c, s, b)] = 8'(base_tb[c] + rows[c] * ((((p == 0) ? wp[c] : wn[c]) >> (2 * s)) & 3)
                                         * ((xv[c] >> b) & 1));
      end
      run_dot(expv, (r == 0) ? "R5" : "R8", 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule